// File: doc/BRIEF.md
# Playback Format Decoder and DMA Byte Pacer

This block turns a one-byte playback format word into the parameters that a sample converter needs: a sample rate, a stereo flag and a sample encoding. When the format is valid and playback is enabled, the block requests DMA. It then accepts DMA bytes over a valid/ready handshake and forwards each one as a 16-bit sample. Mu-law and A-law bytes are expanded to signed linear values. Unsigned 8-bit and 16-bit linear bytes pass through unchanged.

A programmed 16-bit base count, scaled by the sample width and the channel count, sets the number of bytes in one block. While the interrupt enable is set, the block counts accepted bytes. It raises an interrupt when the block is complete and then starts counting the next block from zero.

Back-pressure works as follows. `dma_ready` is high only when all three of these hold:
- the DMA request is active;
- the sink reports enough free space for one output sample;
- with the interrupt enable set, the block target is not zero.

A byte transfers on a rising edge where both `dma_valid` and `dma_ready` are high. The upstream side must hold `dma_data` steady until that edge. There is no output ready: the sink promises its space through `sink_free`.

Top module: `pbk_stream`

## Requirements
- R1: The rate decodes from format bits [3:1] in one of two tables, with bit 0 choosing the table. With bit 0 clear the table is 8000, 16000, 27420, 32000, -, -, 48000, 9000 Hz. With bit 0 set it is 5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620 Hz.
- R2: `stereo` equals format bit 4.
- R3: With `ext_mode` high the encoding is bits [7:5]; otherwise it is {0, bits [6:5]}. The codes are: 0 unsigned 8-bit, 1 mu-law, 2 16-bit linear, 3 A-law, 4 to 7 not usable.
- R4: A format byte of 0x00 or 0x20 is decoded as if bits 4 and 5 were also set.
- R5: `fmt_ok` is low when the rate entry is empty (bit 0 clear with index 4 or 5) or when the encoding code is 4 or higher.
- R6: `dma_req` is low after reset. One clock edge after each input change it equals `play_en AND fmt_ok`.
- R7: `dma_ready` requires `dma_req` and sink space of at least 2 for mu-law or A-law, or at least 1 for the other encodings. With `irq_en` set it also requires a non-zero block target.
- R8: The block target is {base_hi, base_lo} shifted left by a shift value. For 8-bit and companded data the shift is 0 in mono and 1 in stereo. For 16-bit linear data it is 1 in mono and 2 in stereo.
- R9: With `irq_en` set, the byte that brings the running count to the target sets `irq` at that edge and resets the count to zero. `irq` then stays high until the edge that sees `irq_ack`.
- R10: Bytes accepted while `irq_en` is low do not advance the running count.
- R11: Mu-law bytes are expanded as follows. Invert the byte. Take the magnitude as ((mantissa<<3)+132)<<exponent, minus 132, where the exponent is bits [6:4] and the mantissa is bits [3:0]. The result is negative when the inverted bit 7 is set. Examples: 0x00 gives -32124, 0x80 gives 32124, 0xFF gives 0.
- R12: A-law bytes are expanded as follows. XOR the byte with 0x55. Segment 0 gives (mantissa<<4)+8. Segment s>0 gives ((mantissa<<4)+264)<<(s-1). The result is positive when the XORed bit 7 is set. Examples: 0x00 gives -5504, 0xD5 gives 8.
- R13: One edge after a byte is accepted, `smp_valid` is high for one cycle. For unsigned 8-bit and 16-bit linear data, `smp_data` is {0x00, byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_byte | input | 8 | Playback format word |
| ext_mode | input | 1 | Widens the encoding field to three bits |
| play_en | input | 1 | Playback enable |
| irq_en | input | 1 | Enables block counting and the interrupt |
| base_hi | input | BASE_W | Upper half of the base count |
| base_lo | input | BASE_W | Lower half of the base count |
| irq_ack | input | 1 | Clears the interrupt |
| dma_valid | input | 1 | DMA byte valid |
| dma_data | input | 8 | DMA byte |
| dma_ready | output | 1 | Block can accept the byte |
| sink_free | input | SPACE_W | Free sink space, in bytes |
| rate_hz | output | 16 | Decoded sample rate |
| stereo | output | 1 | Two channels |
| encoding | output | 3 | Decoded encoding code |
| fmt_ok | output | 1 | Format is usable |
| dma_req | output | 1 | DMA request |
| smp_valid | output | 1 | Sample strobe |
| smp_data | output | 16 | Sample value |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bench builds the block with `SPACE_W` set to 4. This keeps the sink-space input small, so the thresholds of zero, one and two free bytes can be driven directly. `BASE_W` keeps its default of 8. Small base counts of 1 to 4 are used, so each of the four shift cases finishes a block within a few bytes. This also lets the bench check the zero-target stall and the restart of the count after a block completes.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
  typedef enum logic [2:0] {
    ENC_U8    = 3'd0,
    ENC_MULAW = 3'd1,
    ENC_LIN16 = 3'd2,
    ENC_ALAW  = 3'd3,
    ENC_RSV4  = 3'd4,
    ENC_ADPCM = 3'd5,
    ENC_RSV6  = 3'd6,
    ENC_RSV7  = 3'd7
  } enc_e;

  localparam int RATE_W = 16;
endpackage

// File: rtl/pbk_fmt_decode.sv
module pbk_fmt_decode
  import pbk_pkg::*;
(
  input  logic [7:0]        fmt_byte,
  input  logic              ext_mode,
  output logic [RATE_W-1:0] rate_hz,
  output logic              stereo,
  output enc_e              enc,
  output logic [1:0]        shift,
  output logic              fmt_ok
);
  logic [7:0] eff;
  logic [2:0] idx;
  logic       rate_ok;

  always_comb begin
    eff = fmt_byte;
    if (fmt_byte == 8'h00 || fmt_byte == 8'h20) eff = fmt_byte | 8'h30;
    idx     = eff[3:1];
    rate_ok = 1'b1;
    rate_hz = '0;
    if (!eff[0]) begin
      case (idx)
        3'd0: rate_hz = 16'd8000;
        3'd1: rate_hz = 16'd16000;
        3'd2: rate_hz = 16'd27420;
        3'd3: rate_hz = 16'd32000;
        3'd6: rate_hz = 16'd48000;
        3'd7: rate_hz = 16'd9000;
        default: rate_ok = 1'b0;
      endcase
    end else begin
      case (idx)
        3'd0: rate_hz = 16'd5510;
        3'd1: rate_hz = 16'd11025;
        3'd2: rate_hz = 16'd18900;
        3'd3: rate_hz = 16'd22050;
        3'd4: rate_hz = 16'd37800;
        3'd5: rate_hz = 16'd44100;
        3'd6: rate_hz = 16'd33075;
        default: rate_hz = 16'd6620;
      endcase
    end
    stereo = eff[4];
    enc    = enc_e'(ext_mode ? eff[7:5] : {1'b0, eff[6:5]});
    fmt_ok = rate_ok && !enc[2];
    if (enc == ENC_LIN16) shift = stereo ? 2'd2 : 2'd1;
    else                  shift = {1'b0, stereo};
  end

  always_comb begin
    if (fmt_ok) assert (rate_hz != '0) else $error("p_rate_nonzero_r5");
  end
endmodule

// File: rtl/pbk_law_expand.sv
module pbk_law_expand (
  input  logic [7:0]  code,
  input  logic        use_alaw,
  output logic [15:0] linear
);
  logic [7:0]  m;
  logic [7:0]  a;
  logic [15:0] mu_mag;
  logic [15:0] al_mag;
  logic [15:0] mu_val;
  logic [15:0] al_val;

  always_comb begin
    m      = ~code;
    mu_mag = ((16'({m[3:0], 3'b000}) + 16'd132) << m[6:4]) - 16'd132;
    mu_val = m[7] ? (16'd0 - mu_mag) : mu_mag;

    a = code ^ 8'h55;
    if (a[6:4] == 3'd0) al_mag = 16'({a[3:0], 4'b0000}) + 16'd8;
    else                al_mag = (16'({a[3:0], 4'b0000}) + 16'd264) << (a[6:4] - 3'd1);
    al_val = a[7] ? al_mag : (16'd0 - al_mag);

    linear = use_alaw ? al_val : mu_val;
  end
endmodule

// File: rtl/pbk_stream.sv
module pbk_stream
  import pbk_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int SPACE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         fmt_byte,
  input  logic               ext_mode,
  input  logic               play_en,
  input  logic               irq_en,
  input  logic [BASE_W-1:0]  base_hi,
  input  logic [BASE_W-1:0]  base_lo,
  input  logic               irq_ack,
  input  logic               dma_valid,
  input  logic [7:0]         dma_data,
  output logic               dma_ready,
  input  logic [SPACE_W-1:0] sink_free,
  output logic [15:0]        rate_hz,
  output logic               stereo,
  output logic [2:0]         encoding,
  output logic               fmt_ok,
  output logic               dma_req,
  output logic               smp_valid,
  output logic [15:0]        smp_data,
  output logic               irq
);
  localparam int CNT_W = 2 * BASE_W + 2;

  enc_e              enc;
  logic [1:0]        shift;
  logic [15:0]       expanded;
  logic              companded;
  logic              room_ok;
  logic              target_ok;
  logic              take;
  logic [CNT_W-1:0]  target;
  logic [CNT_W-1:0]  byte_cnt;
  logic [CNT_W-1:0]  cnt_next;

  pbk_fmt_decode u_dec (
    .fmt_byte (fmt_byte),
    .ext_mode (ext_mode),
    .rate_hz  (rate_hz),
    .stereo   (stereo),
    .enc      (enc),
    .shift    (shift),
    .fmt_ok   (fmt_ok)
  );

  pbk_law_expand u_law (
    .code     (dma_data),
    .use_alaw (enc == ENC_ALAW),
    .linear   (expanded)
  );

  assign encoding  = enc;
  assign companded = (enc == ENC_MULAW) || (enc == ENC_ALAW);
  assign target    = CNT_W'({base_hi, base_lo}) << shift;
  assign room_ok   = companded ? (sink_free >= SPACE_W'(2)) : (sink_free != '0);
  assign target_ok = !irq_en || (target != '0);
  assign dma_ready = dma_req && room_ok && target_ok;
  assign take      = dma_valid && dma_ready;
  assign cnt_next  = byte_cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req   <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      byte_cnt  <= '0;
      irq       <= 1'b0;
    end else begin
      dma_req   <= play_en && fmt_ok;
      smp_valid <= take;
      if (take) smp_data <= companded ? expanded : {8'h00, dma_data};
      if (irq_ack) irq <= 1'b0;
      if (take && irq_en) begin
        if (cnt_next >= target) begin
          byte_cnt <= '0;
          irq      <= 1'b1;
        end else begin
          byte_cnt <= cnt_next;
        end
      end
    end
  end

  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> !dma_req);
  p_sample_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready) |=> smp_valid);
  p_no_spurious_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_valid && dma_ready) |=> !smp_valid);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !irq_en) |=> !irq);
endmodule

// File: tb/pbk_stream_test.sv
module pbk_stream_test;
  localparam int CLK_NS = 10;
  localparam int BW = 8;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] fmt_byte = 8'h01;
  logic ext_mode = 1'b0, play_en = 1'b0, irq_en = 1'b0, irq_ack = 1'b0;
  logic [BW-1:0] base_hi = '0, base_lo = '0;
  logic dma_valid = 1'b0;
  logic [7:0] dma_data = '0;
  logic [SW-1:0] sink_free = 4'd15;
  logic dma_ready, stereo, fmt_ok, dma_req, smp_valid, irq;
  logic [15:0] rate_hz, smp_data;
  logic [2:0] encoding;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  pbk_stream #(.BASE_W(BW), .SPACE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .fmt_byte(fmt_byte), .ext_mode(ext_mode),
    .play_en(play_en), .irq_en(irq_en), .base_hi(base_hi), .base_lo(base_lo),
    .irq_ack(irq_ack), .dma_valid(dma_valid), .dma_data(dma_data),
    .dma_ready(dma_ready), .sink_free(sink_free), .rate_hz(rate_hz),
    .stereo(stereo), .encoding(encoding), .fmt_ok(fmt_ok), .dma_req(dma_req),
    .smp_valid(smp_valid), .smp_data(smp_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    dma_valid = 1'b1;
    dma_data  = b;
    while (!dma_ready) @(negedge clk);
    @(posedge clk);
    #1 dma_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_fmt(input logic [7:0] f);
    @(negedge clk);
    fmt_byte = f;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R6 reset dma_req", dma_req, 0);
    check("R9 reset irq", irq, 0);
    check("R13 reset smp_valid", smp_valid, 0);
  endtask

  task automatic t_rates;
    set_fmt(8'h0B); check("R1 44100", rate_hz, 44100);
    set_fmt(8'h07); check("R1 22050", rate_hz, 22050);
    set_fmt(8'h0C); check("R1 48000", rate_hz, 48000);
    set_fmt(8'h0E); check("R1 9000", rate_hz, 9000);
    set_fmt(8'h08); check("R5 empty rate", fmt_ok, 0);
    set_fmt(8'h11); check("R2 stereo", stereo, 1);
    set_fmt(8'h01); check("R2 mono", stereo, 0);
  endtask

  task automatic t_encoding;
    ext_mode = 1'b1; set_fmt(8'hA1);
    check("R3 wide enc", encoding, 5);
    check("R5 adpcm unusable", fmt_ok, 0);
    ext_mode = 1'b0; set_fmt(8'hA1);
    check("R3 narrow enc", encoding, 1);
    check("R5 narrow ok", fmt_ok, 1);
    set_fmt(8'h00);
    check("R4 zero rate", rate_hz, 8000);
    check("R4 zero stereo", stereo, 1);
    check("R4 zero enc", encoding, 1);
    set_fmt(8'h20);
    check("R4 0x20 stereo", stereo, 1);
  endtask

  task automatic t_request;
    set_fmt(8'h01); play_en = 1'b1;
    @(negedge clk); check("R6 req on", dma_req, 1);
    set_fmt(8'h08); check("R6 req off bad fmt", dma_req, 0);
    set_fmt(8'h01); play_en = 1'b0;
    @(negedge clk); check("R6 req off disable", dma_req, 0);
    play_en = 1'b1; @(negedge clk);
  endtask

  task automatic t_data;
    set_fmt(8'h01); push(8'hA5);
    check("R13 strobe", smp_valid, 1);
    check("R13 pass", smp_data, 16'h00A5);
    @(negedge clk); check("R13 one cycle", smp_valid, 0);
    set_fmt(8'h41); push(8'h3C); check("R13 lin16 pass", smp_data, 16'h003C);
    set_fmt(8'h21);
    push(8'h00); check("R11 mu 00", smp_data, 16'h8284);
    push(8'h80); check("R11 mu 80", smp_data, 16'h7D7C);
    push(8'hFF); check("R11 mu ff", smp_data, 16'h0000);
    set_fmt(8'h61);
    push(8'h00); check("R12 a 00", smp_data, 16'hEA80);
    push(8'hD5); check("R12 a d5", smp_data, 16'h0008);
  endtask

  task automatic t_room;
    set_fmt(8'h61); sink_free = 4'd1;
    @(negedge clk); check("R7 alaw needs 2", dma_ready, 0);
    sink_free = 4'd2; @(negedge clk); check("R7 alaw 2 ok", dma_ready, 1);
    set_fmt(8'h01); sink_free = 4'd1;
    @(negedge clk); check("R7 u8 1 ok", dma_ready, 1);
    sink_free = 4'd0; @(negedge clk); check("R7 no room", dma_ready, 0);
    sink_free = 4'd15;
    irq_en = 1'b1; base_hi = '0; base_lo = '0;
    @(negedge clk); check("R7 zero target", dma_ready, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_count;
    set_fmt(8'h01); base_lo = 8'd3; irq_en = 1'b1;
    push(8'h1); push(8'h2); check("R9 early", irq, 0);
    push(8'h3); check("R9 fire", irq, 1);
    @(negedge clk); @(negedge clk); check("R9 held", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R9 acked", irq, 0);
    push(8'h4); push(8'h5); check("R9 restart early", irq, 0);
    push(8'h6); check("R9 restart fire", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    set_fmt(8'h51); base_lo = 8'd2;
    for (int i = 0; i < 7; i++) push(8'(i));
    check("R8 lin16 stereo before", irq, 0);
    push(8'h7); check("R8 lin16 stereo x4", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    set_fmt(8'h41);
    for (int i = 0; i < 3; i++) push(8'(i));
    check("R8 lin16 mono before", irq, 0);
    push(8'h3); check("R8 lin16 mono x2", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    set_fmt(8'h11); base_lo = 8'd1;
    push(8'h0); check("R8 u8 stereo before", irq, 0);
    push(8'h1); check("R8 u8 stereo x2", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_hold;
    set_fmt(8'h01); base_lo = 8'd4; irq_en = 1'b0;
    for (int i = 0; i < 3; i++) push(8'(i));
    check("R10 no irq off", irq, 0);
    irq_en = 1'b1;
    for (int i = 0; i < 3; i++) push(8'(i));
    check("R10 count held", irq, 0);
    push(8'h9); check("R10 fourth", irq, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R7 watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates();
    t_encoding();
    t_request();
    t_data();
    t_room();
    t_count();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule